// File: doc/BRIEF.md
# Paired Edge-Capture Unit

This block serves two capture channels, a lower channel and an upper channel, from one shared 8-bit control byte. Each channel samples an external pin through a synchronizer. It compares the current synchronized sample with the previous one, and on the edge kind that its mode field selects it copies the value of an external free-running counter into its own capture register. In the same step it sets a sticky detection flag.

An enable bit per channel passes that flag to the channel's interrupt output. Software clears a flag by writing 0 to its bit. Writing 1 to a flag bit leaves it as it is. A mode code of 00 turns the channel off. The counter, the interrupt controller and the electrical behaviour of the pins are outside this block.

Top module: `cap_pair_unit`

## Requirements
- R1: After reset, the control byte reads 0x00, both capture registers read 0 and both interrupt outputs are 0.
- R2: With mode 01 (rising), a 0-to-1 change on the pin sets the channel's flag and a 1-to-0 change does not. A pin change that is set up before rising clock edge k becomes visible on the bus after edge k+2, and is not visible after edge k+1.
- R3: With mode 10 (falling), a 1-to-0 change on the pin sets the flag and a 0-to-1 change does not.
- R4: With mode 11 (both), either direction of pin change sets the flag.
- R5: With mode 00, no pin change sets the flag or alters the capture register.
- R6: When a valid edge is detected, the channel's capture register takes the counter value presented in the clock cycle before the edge at which the flag sets. For a pin change set up before edge k, that is the value the counter holds after edge k+1. Bus addresses: 0 is the control byte, 1 is the lower capture register, 2 is the upper capture register.
- R7: A write to address 0 with 0 in a flag bit clears that flag. A 1 in a flag bit leaves it unchanged. Once set, a flag stays set until it is cleared this way.
- R8: When a valid edge and a write-0 clear of the same flag fall in the same cycle, the flag ends up set.
- R9: Each interrupt output is 1 exactly when that channel's flag and its enable bit are both 1.
- R10: Control-byte layout: bit7 is the upper flag, bit6 the lower flag, bit5 the upper enable, bit4 the lower enable, bits 3:2 the upper mode and bits 1:0 the lower mode. The two channels act independently.
- R11: Bus writes to addresses 1 and 2 have no effect on the capture registers or on the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from bus_addr |
| cap_pin_lo | input | 1 | Lower channel capture pin |
| cap_pin_hi | input | 1 | Upper channel capture pin |
| tmr_count | input | CNT_W | Free-running counter value |
| irq_lo | output | 1 | Lower channel interrupt request |
| irq_hi | output | 1 | Upper channel interrupt request |

## Verification
The bench drives a pin change together with a clear write in the same cycle. A design that lets the clear win would lose that event and read the flag as 0. Each mode is driven with both pin directions, so a design with the rising and falling codes swapped, or one that still detects in mode 00, sets a flag where none is expected. Capture values are compared against a counter that advances every cycle, which exposes a synchronizer one stage short or long as a capture off by one count and a flag that appears a cycle early or late. Writes of 1 to flag bits and writes to the read-only capture addresses are read back, so a design that toggles flags or lets software load a capture register shows the wrong value.

// File: rtl/cap_pair_pkg.sv
package cap_pair_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

   localparam int CTRL_W      = 8;
   localparam int NUM_CH      = 2;
   localparam int FLAG_BASE   = 6;  // flag of channel i at bit FLAG_BASE+i
   localparam int IE_BASE     = 4;  // enable of channel i at bit IE_BASE+i
   localparam logic [1:0] ADDR_CTRL   = 2'd0;
   localparam logic [1:0] ADDR_CAP_LO = 2'd1;
   localparam logic [1:0] ADDR_CAP_HI = 2'd2;

   function automatic logic edge_hit(edge_mode_e mode, logic cur, logic prv);
      case (mode)
         EDGE_RISE: edge_hit = cur & ~prv;
         EDGE_FALL: edge_hit = ~cur & prv;
         EDGE_BOTH: edge_hit = cur ^ prv;
         default:   edge_hit = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cap_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det
   import cap_pair_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  edge_mode_e mode,
   input  logic       smp,
   output logic       hit
);
   logic prv_q;

   // previous sample tracks always, so enabling a mode never fakes an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv_q <= 1'b0;
      else        prv_q <= smp;
   end

   assign hit = edge_hit(mode, smp, prv_q);
endmodule

// File: rtl/cap_channel.sv
module cap_channel
   import cap_pair_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  edge_mode_e       mode,
   input  logic [CNT_W-1:0] cnt,
   output logic             evt,
   output logic [CNT_W-1:0] cap
);
   logic smp;

   cap_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pin), .q(smp)
   );

   cap_edge_det det_i (
      .clk(clk), .rst_n(rst_n), .mode(mode), .smp(smp), .hit(evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cap <= '0;
      else if (evt) cap <= cnt;
   end
endmodule

// File: rtl/cap_pair_unit.sv
module cap_pair_unit
   import cap_pair_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             cap_pin_lo,
   input  logic             cap_pin_hi,
   input  logic [CNT_W-1:0] tmr_count,
   output logic             irq_lo,
   output logic             irq_hi
);
   localparam int CFG_W = FLAG_BASE;

   generate
      if (CNT_W < CTRL_W) begin : g_bad_w
         $error("cap_pair_unit: CNT_W must cover the control byte");
      end
      if (SYNC_STAGES < 2) begin : g_bad_s
         $error("cap_pair_unit: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CFG_W-1:0]  cfg_q;
   logic [NUM_CH-1:0] flag_q;
   logic [NUM_CH-1:0] evt;
   logic [NUM_CH-1:0] pins;
   logic [NUM_CH-1:0] irq;
   logic [CNT_W-1:0]  cap_q [NUM_CH];
   logic [CNT_W-1:0]  cap_lo, cap_hi;
   logic [CTRL_W-1:0] ctrl_view;
   logic              wr_ctrl;

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
   assign pins    = {cap_pin_hi, cap_pin_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q <= '0;
      else if (wr_ctrl) cfg_q <= bus_wdata[CFG_W-1:0];
   end

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         cap_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) ch_i (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[i]),
            .mode (edge_mode_e'(cfg_q[2*i +: 2])),
            .cnt  (tmr_count),
            .evt  (evt[i]),
            .cap  (cap_q[i])
         );

         // hardware set has priority over a software clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= evt[i] |
                                     (flag_q[i] & ~(wr_ctrl & ~bus_wdata[FLAG_BASE+i]));
         end

         assign irq[i] = flag_q[i] & cfg_q[IE_BASE+i];
      end
   endgenerate

   assign cap_lo    = cap_q[0];
   assign cap_hi    = cap_q[1];
   assign ctrl_view = {flag_q, cfg_q};
   assign irq_lo    = irq[0];
   assign irq_hi    = irq[1];

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_CTRL:   bus_rdata[CTRL_W-1:0] = ctrl_view;
         ADDR_CAP_LO: bus_rdata = cap_lo;
         ADDR_CAP_HI: bus_rdata = cap_hi;
         default:     bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cap_pair_chk.sv
module cap_pair_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [1:0]       bus_addr,
   input logic [1:0]       wflags,
   input logic [CNT_W-1:0] tmr_count,
   input logic [7:0]       ctrl_view,
   input logic [1:0]       evt,
   input logic [CNT_W-1:0] cap_lo,
   input logic [CNT_W-1:0] cap_hi
);
   logic wr_ctrl;
   assign wr_ctrl = bus_wr && (bus_addr == 2'd0);

   assert_event_sets_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt[0] |=> ctrl_view[6]);
   assert_event_sets_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt[1] |=> ctrl_view[7]);

   assert_sticky_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_view[6] && !(wr_ctrl && !wflags[0])) |=> ctrl_view[6]);
   assert_clear_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wflags[0] && !evt[0]) |=> !ctrl_view[6]);

   assert_off_quiet_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_view[1:0] == 2'b00) |-> !evt[0]);
   assert_off_quiet_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_view[3:2] == 2'b00) |-> !evt[1]);

   assert_capture_value_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt[0] |=> (cap_lo == $past(tmr_count)));
   assert_capture_value_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt[1] |=> (cap_hi == $past(tmr_count)));

   assert_capture_hold_lo_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !evt[0] |=> $stable(cap_lo));
   assert_capture_hold_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !evt[1] |=> $stable(cap_hi));
endmodule

bind cap_pair_unit cap_pair_chk #(.CNT_W(CNT_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .wflags   (bus_wdata[7:6]),
   .tmr_count(tmr_count),
   .ctrl_view(ctrl_view),
   .evt      (evt),
   .cap_lo   (cap_lo),
   .cap_hi   (cap_hi)
);

// File: tb/cap_pair_unit_tb_top.sv
`timescale 1ns/1ps
module cap_pair_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [15:0] bus_rdata;
   logic        cap_pin_lo = 1'b0;
   logic        cap_pin_hi = 1'b0;
   logic [15:0] tmr_count = 16'h0000;
   logic        irq_lo, irq_hi;

   int errs = 0;
   int checks = 0;
   logic [7:0] cfg = 8'h00;

   always #10 clk = ~clk;
   always @(posedge clk) tmr_count <= tmr_count + 16'd1;

   cap_pair_unit dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_pin_lo(cap_pin_lo), .cap_pin_hi(cap_pin_hi),
      .tmr_count(tmr_count), .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic clear_flags();
      wr(2'd0, {2'b00, cfg[5:0]});
   endtask

   // drive pin of channel ch to val; expect a capture when hit is 1
   task automatic edge_case(input int ch, input logic val, input logic hit, input string req);
      logic [15:0] old_cap, c0, v;
      rd(2'(1 + ch), old_cap);
      c0 = tmr_count;
      if (ch == 0) cap_pin_lo = val; else cap_pin_hi = val;
      @(negedge clk); @(negedge clk);
      rd(2'd0, v);
      check({req, " flag not yet after two edges"}, 32'(v[6+ch]), 32'd0);
      @(negedge clk);
      rd(2'd0, v);
      check({req, " flag after third edge"}, 32'(v[6+ch]), 32'(hit));
      rd(2'(1 + ch), v);
      check(hit ? "R6 capture value" : "R5 capture untouched", 32'(v),
            32'(hit ? 16'(c0 + 16'd2) : old_cap));
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd(2'd0, v); check("R1 control byte", 32'(v), 32'h0);
      rd(2'd1, v); check("R1 lower capture", 32'(v), 32'h0);
      rd(2'd2, v); check("R1 upper capture", 32'(v), 32'h0);
      check("R1 irq_lo", 32'(irq_lo), 32'h0);
      check("R1 irq_hi", 32'(irq_hi), 32'h0);
   endtask

   task automatic t_off();
      edge_case(0, 1'b1, 1'b0, "R5");
      edge_case(0, 1'b0, 1'b0, "R5");
   endtask

   task automatic t_rise();
      cfg = 8'h01; wr(2'd0, cfg);
      edge_case(0, 1'b1, 1'b1, "R2");
      clear_flags();
      edge_case(0, 1'b0, 1'b0, "R2");
   endtask

   task automatic t_fall();
      cfg = 8'h02; wr(2'd0, cfg);
      edge_case(0, 1'b1, 1'b0, "R3");
      edge_case(0, 1'b0, 1'b1, "R3");
      clear_flags();
   endtask

   task automatic t_both();
      cfg = 8'h03; wr(2'd0, cfg);
      edge_case(0, 1'b1, 1'b1, "R4");
      clear_flags();
      edge_case(0, 1'b0, 1'b1, "R4");
      clear_flags();
   endtask

   task automatic t_upper();
      logic [15:0] v;
      cfg = 8'h04; wr(2'd0, cfg);
      edge_case(1, 1'b1, 1'b1, "R10");
      rd(2'd0, v);
      check("R10 control byte, upper flag only", 32'(v), 32'h84);
   endtask

   task automatic t_clear();
      logic [15:0] v;
      wr(2'd0, 8'hC4);
      rd(2'd0, v); check("R7 write 1 keeps flag", 32'(v), 32'h84);
      wr(2'd0, 8'h44);
      rd(2'd0, v); check("R7 write 0 clears flag", 32'(v), 32'h04);
   endtask

   task automatic t_irq();
      cfg = 8'h01; wr(2'd0, cfg);
      edge_case(0, 1'b1, 1'b1, "R9");
      check("R9 irq_lo masked", 32'(irq_lo), 32'h0);
      cfg = 8'h11; wr(2'd0, 8'hD1);
      check("R9 irq_lo enabled", 32'(irq_lo), 32'h1);
      check("R9 irq_hi stays low", 32'(irq_hi), 32'h0);
      clear_flags();
      check("R9 irq_lo after clear", 32'(irq_lo), 32'h0);
   endtask

   task automatic t_set_wins();
      logic [15:0] v, c0;
      cfg = 8'h03; wr(2'd0, cfg);
      edge_case(0, 1'b0, 1'b1, "R8");
      c0 = tmr_count;
      cap_pin_lo = 1'b1;
      @(negedge clk); @(negedge clk);
      wr(2'd0, 8'h03);
      rd(2'd0, v); check("R8 set beats clear", 32'(v[6]), 32'h1);
      rd(2'd1, v); check("R8 capture on collided edge", 32'(v), 32'(16'(c0 + 16'd2)));
      wr(2'd0, 8'h03);
      rd(2'd0, v); check("R7 plain clear", 32'(v[6]), 32'h0);
   endtask

   task automatic t_readonly();
      logic [15:0] lo0, hi0, v;
      rd(2'd1, lo0); rd(2'd2, hi0);
      wr(2'd1, 8'h5A);
      wr(2'd2, 8'hA5);
      rd(2'd1, v); check("R11 lower capture unchanged", 32'(v), 32'(lo0));
      rd(2'd2, v); check("R11 upper capture unchanged", 32'(v), 32'(hi0));
      rd(2'd0, v); check("R11 control unchanged", 32'(v), 32'h03);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_off();
      t_rise();
      t_fall();
      t_both();
      t_upper();
      t_clear();
      t_irq();
      t_set_wins();
      t_readonly();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #4000000;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule